// File: doc/BRIEF.md
# Serial DAC Command Interface Controller

This block is the digital core of a 13-bit serial-input converter. A three-wire slave port (active-low select, serial clock, serial data) fills a 16-bit shift register, most significant bit first. The upper three bits form an opcode and the lower thirteen carry a code. When select returns high after exactly sixteen clocks, the opcode is decoded. It can write a holding register, write the output register, copy holding to output, drive a general-purpose logic output, enter a software shutdown, or choose the edge on which the daisy-chain output moves.

The serial pins, the clear pin, the shutdown lockout pin and the hardware shutdown request pin are brought into the system clock domain through two-flop synchronizers. Edges are detected in that domain, so the system clock must run at least four times faster than the serial clock. The analog output stage lies outside this block. An output-enable flag stands in for the converter output going high-impedance during shutdown.

Top module: `dacif_core`

## Requirements
- R1: A word is 16 bits, shifted in MSB first on synchronized SCLK rising edges while `csN` is low. Bits [15:13] are the opcode and bits [12:0] are the code. The word executes when `csN` rises.
- R2: When `csN` rises after any count other than 16 rising edges, the word is dropped and no register or output changes.
- R3: Opcode 001 writes the code into the holding register and leaves `dacCode` unchanged.
- R4: Opcode 010 writes the code into both the holding register and the output register. Opcode 011 copies the holding register into the output register. Both opcodes end any shutdown.
- R5: Opcode 101 drives `userOut` high and opcode 100 drives it low. Opcodes 000 and 110 change nothing.
- R6: Opcode 111 with bit 12 set enters shutdown (`outEnable` low) when `pdLock` is high. The stored codes are kept, and serial commands still execute during shutdown.
- R7: While `pdLock` is low, neither the software command nor `pdReq` can cause a shutdown. A high-to-low transition on `pdLock` ends a shutdown.
- R8: A high level on `pdReq` with `pdLock` high enters shutdown. Lowering `pdReq` again does not end it.
- R9: While `clrN` is low, the output register takes the reset value (0 when `rstVal` is 0, 0x1000 when `rstVal` is 1), shutdown ends and `userOut` goes low.
- R10: After `rst_n`, both the holding and output registers hold the reset value chosen by `rstVal`, `outEnable` is 1, `userOut` is 0 and the DOUT mode is 0.
- R11: Opcode 111 with bit 12 clear and bit 11 clear selects mode 0. In mode 0, `dout` takes the shift-register MSB on each SCLK falling edge, so a word reappears 16 clocks later.
- R12: Opcode 111 with bit 12 clear and bit 11 set selects mode 1. In mode 1, `dout` moves on each rising edge to the new shift-register MSB, half a clock earlier than in mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous power-up reset |
| csN | input | 1 | Active-low serial select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| clrN | input | 1 | Active-low clear to reset value |
| rstVal | input | 1 | Reset value select: 0 = zero, 1 = midscale |
| pdLock | input | 1 | Shutdown lockout, low forbids shutdown |
| pdReq | input | 1 | Hardware shutdown request, active high |
| dacCode | output | 13 | Output register contents |
| outEnable | output | 1 | Analog output enabled (low in shutdown) |
| userOut | output | 1 | General-purpose logic output |
| dout | output | 1 | Daisy-chain serial output |

## Verification
The bench builds the block with its default parameters: a 13-bit code, a 3-bit opcode and two synchronizer stages. It drives the serial clock at one sixteenth of the system rate, which leaves room to sample `dout` between a rising and a falling edge. That is the only point where the two DOUT modes differ, by one bit position. The 13-bit code reaches both the all-ones code and the 0x1000 midscale reset value. With the short synchronizer chain, the lockout and clear windows that the checker watches stay at a few cycles.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int DATA_W = 13;
  localparam int CMD_W  = 3;
  localparam int WORD_W = DATA_W + CMD_W;
  localparam int CNT_W  = $clog2(WORD_W + 2);

  typedef enum logic [CMD_W-1:0] {
    OP_NOP       = 3'd0,
    OP_LOAD_IN   = 3'd1,
    OP_LOAD_BOTH = 3'd2,
    OP_UPDATE    = 3'd3,
    OP_UPO_LO    = 3'd4,
    OP_UPO_HI    = 3'd5,
    OP_SPARE     = 3'd6,
    OP_CONFIG    = 3'd7
  } opcode_e;

  typedef struct packed {
    logic              loadIn;
    logic              loadBoth;
    logic              update;
    logic              upoLo;
    logic              upoHi;
    logic              swShut;
    logic              setMode;
    logic              modeVal;
    logic [DATA_W-1:0] data;
  } strobe_t;
endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int          N       = 1,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] asyncIn,
  output logic [N-1:0] syncOut
);
  for (genvar g = 0; g < N; g++) begin : gSync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], asyncIn[g]};
    end
    assign syncOut[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sclkS,
  input  logic    csNS,
  input  logic    dinS,
  output strobe_t st,
  output logic    dout
);
  logic              sclkPrev, csPrev;
  logic              sclkRise, sclkFall, csRise, csFall, csLow;
  logic [WORD_W-1:0] shiftReg;
  logic [CNT_W-1:0]  bitCnt;
  logic              doutMode;
  opcode_e           op;

  assign sclkRise = sclkS & ~sclkPrev;
  assign sclkFall = ~sclkS & sclkPrev;
  assign csRise   = csNS & ~csPrev;
  assign csFall   = ~csNS & csPrev;
  assign csLow    = ~csNS;
  assign op       = opcode_e'(shiftReg[WORD_W-1 -: CMD_W]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclkPrev <= 1'b0;
      csPrev   <= 1'b1;
      shiftReg <= '0;
      bitCnt   <= '0;
      dout     <= 1'b0;
      doutMode <= 1'b0;
    end else begin
      sclkPrev <= sclkS;
      csPrev   <= csNS;
      if (csFall) begin
        bitCnt <= '0;
      end else if (sclkRise && csLow) begin
        shiftReg <= {shiftReg[WORD_W-2:0], dinS};
        if (bitCnt != {CNT_W{1'b1}}) bitCnt <= bitCnt + 1'b1;
      end
      if (sclkRise && csLow && doutMode)      dout <= shiftReg[WORD_W-2];
      else if (sclkFall && !doutMode)         dout <= shiftReg[WORD_W-1];
      if (st.setMode) doutMode <= st.modeVal;
    end
  end

  always_comb begin
    st      = '0;
    st.data = shiftReg[DATA_W-1:0];
    if (csRise && bitCnt == CNT_W'(WORD_W)) begin
      unique case (op)
        OP_LOAD_IN:   st.loadIn   = 1'b1;
        OP_LOAD_BOTH: st.loadBoth = 1'b1;
        OP_UPDATE:    st.update   = 1'b1;
        OP_UPO_LO:    st.upoLo    = 1'b1;
        OP_UPO_HI:    st.upoHi    = 1'b1;
        OP_CONFIG: begin
          if (shiftReg[DATA_W-1]) st.swShut = 1'b1;
          else begin
            st.setMode = 1'b1;
            st.modeVal = shiftReg[DATA_W-2];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           st,
  input  logic              clrS,
  input  logic              lockS,
  input  logic              pdS,
  input  logic              rstVal,
  output logic [DATA_W-1:0] dacCode,
  output logic              outEnable,
  output logic              userOut
);
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [DATA_W-1:0] inReg, dacReg, resetCode;
  logic              shut, upo, lockPrev, lockFall;

  assign resetCode = rstVal ? MID : '0;
  assign lockFall  = ~lockS & lockPrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inReg    <= resetCode;
      dacReg   <= resetCode;
      shut     <= 1'b0;
      upo      <= 1'b0;
      lockPrev <= 1'b1;
    end else begin
      lockPrev <= lockS;
      if (st.loadIn || st.loadBoth) inReg <= st.data;

      if (!clrS)            dacReg <= resetCode;
      else if (st.loadBoth) dacReg <= st.data;
      else if (st.update)   dacReg <= inReg;

      if (!clrS)          upo <= 1'b0;
      else if (st.upoHi)  upo <= 1'b1;
      else if (st.upoLo)  upo <= 1'b0;

      if (!clrS || lockFall)               shut <= 1'b0;
      else if (st.swShut && lockS)         shut <= 1'b1;
      else if (st.loadBoth || st.update)   shut <= 1'b0;
      else if (pdS && lockS)               shut <= 1'b1;
    end
  end

  assign dacCode   = dacReg;
  assign outEnable = ~shut;
  assign userOut   = upo;
endmodule

// File: rtl/dacif_core.sv
module dacif_core
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              clrN,
  input  logic              rstVal,
  input  logic              pdLock,
  input  logic              pdReq,
  output logic [DATA_W-1:0] dacCode,
  output logic              outEnable,
  output logic              userOut,
  output logic              dout
);
  localparam int PIN_N = 6;
  localparam logic [PIN_N-1:0] PIN_RST = 6'b011010;

  logic [PIN_N-1:0] syncBus;
  logic             sclkS, csNS, dinS, clrS, lockS, pdS;
  strobe_t          st;

  dacif_sync #(.N(PIN_N), .STAGES(SYNC_STAGES), .RST_VAL(PIN_RST)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .asyncIn({pdReq, pdLock, clrN, din, csN, sclk}),
    .syncOut(syncBus)
  );
  assign {pdS, lockS, clrS, dinS, csNS, sclkS} = syncBus;

  dacif_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclkS(sclkS), .csNS(csNS), .dinS(dinS),
    .st(st), .dout(dout)
  );

  dacif_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .clrS(clrS), .lockS(lockS),
    .pdS(pdS), .rstVal(rstVal), .dacCode(dacCode),
    .outEnable(outEnable), .userOut(userOut)
  );
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
  import dacif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              pdLock,
  input logic              clrN,
  input logic              rstVal,
  input logic [DATA_W-1:0] dacCode,
  input logic              outEnable,
  input logic              userOut,
  input strobe_t           st,
  input logic              lockS,
  input logic              clrS
);
  // R7
  lock_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pdLock && $past(!pdLock) && $past(!pdLock, 2) && $past(!pdLock, 3)
      && $past(!pdLock, 4) && $past(!pdLock, 5)) |-> outEnable);

  // R9
  clear_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clrN && $past(!clrN) && $past(!clrN, 2) && $past(!clrN, 3) && $stable(rstVal))
      |-> (dacCode == (rstVal ? DATA_W'(1) << (DATA_W - 1) : '0)) && !userOut && outEnable);

  // R2
  dac_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dacCode) |-> $past(st.loadBoth || st.update || !clrS));

  // R6
  shut_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(outEnable) |-> $past(lockS));

  // R1
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st.loadIn, st.loadBoth, st.update, st.upoLo, st.upoHi, st.swShut, st.setMode}));
endmodule

bind dacif_core dacif_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pdLock(pdLock), .clrN(clrN), .rstVal(rstVal),
  .dacCode(dacCode), .outEnable(outEnable), .userOut(userOut),
  .st(st), .lockS(lockS), .clrS(clrS)
);

// File: tb/dacif_core_tb.sv
module dacif_core_tb;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0, csN = 1'b1, sclk = 1'b0, din = 1'b0;
  logic clrN = 1'b1, rstVal = 1'b0, pdLock = 1'b1, pdReq = 1'b0;
  logic [12:0] dacCode;
  logic outEnable, userOut, dout;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  dacif_core u_dut (
    .clk(clk), .rst_n(rst_n), .csN(csN), .sclk(sclk), .din(din),
    .clrN(clrN), .rstVal(rstVal), .pdLock(pdLock), .pdReq(pdReq),
    .dacCode(dacCode), .outEnable(outEnable), .userOut(userOut), .dout(dout)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shiftWord(input logic [15:0] w, input int nBits,
                           input bit doChk, input logic [15:0] prevW, input bit mode1);
    csN = 1'b0;
    tick(HALF);
    for (int i = 0; i < nBits; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      tick(HALF);
      if (doChk) chk(mode1 ? "R12 pre-rise" : "R11 pre-rise", 16'(dout), 16'(prevW[15-i]));
      sclk = 1'b1;
      tick(HALF);
      if (doChk && i < 15)
        chk(mode1 ? "R12 mid" : "R11 mid", 16'(dout), 16'(mode1 ? prevW[14-i] : prevW[15-i]));
      sclk = 1'b0;
    end
    tick(HALF);
    csN = 1'b1;
    tick(12);
  endtask

  task automatic send(input logic [15:0] w);
    shiftWord(w, 16, 1'b0, 16'h0, 1'b0);
  endtask

  task automatic doReset(input logic rv);
    rst_n = 1'b0;
    rstVal = rv;
    tick(5);
    rst_n = 1'b1;
    tick(5);
  endtask

  task automatic clearPulse();
    clrN = 1'b0;
    tick(6);
    clrN = 1'b1;
    tick(6);
  endtask

  task automatic testReset();
    doReset(1'b1);
    chk("R10 dac midscale", 16'(dacCode), 16'h1000);
    chk("R10 outEnable", 16'(outEnable), 16'h1);
    chk("R10 userOut", 16'(userOut), 16'h0);
    rstVal = 1'b0;
    clearPulse();
    chk("R9 clear to zero", 16'(dacCode), 16'h0000);
    send(16'h6000);
    chk("R10 holding reg reset value", 16'(dacCode), 16'h1000);
    doReset(1'b0);
    chk("R10 dac zero", 16'(dacCode), 16'h0000);
  endtask

  task automatic testLoad();
    send(16'h2ABC);
    chk("R3 load holding only", 16'(dacCode), 16'h0000);
    send(16'h6000);
    chk("R4 update from holding", 16'(dacCode), 16'h0ABC);
    send(16'h5FFF);
    chk("R1 R4 load both all ones", 16'(dacCode), 16'h1FFF);
  endtask

  task automatic testShort();
    shiftWord(16'h4123, 15, 1'b0, 16'h0, 1'b0);
    chk("R2 15-bit word dropped", 16'(dacCode), 16'h1FFF);
    shiftWord(16'h4123, 17, 1'b0, 16'h0, 1'b0);
    chk("R2 17-bit word dropped", 16'(dacCode), 16'h1FFF);
    shiftWord(16'hA000, 15, 1'b0, 16'h0, 1'b0);
    chk("R2 short user-out word dropped", 16'(userOut), 16'h0);
  endtask

  task automatic testUpo();
    send(16'hA000);
    chk("R5 userOut high", 16'(userOut), 16'h1);
    send(16'h0000);
    send(16'hC123);
    chk("R5 nop/spare keep userOut", 16'(userOut), 16'h1);
    chk("R5 nop/spare keep dac", 16'(dacCode), 16'h1FFF);
    send(16'h8000);
    chk("R5 userOut low", 16'(userOut), 16'h0);
  endtask

  task automatic testShut();
    send(16'hF000);
    chk("R6 shutdown disables output", 16'(outEnable), 16'h0);
    chk("R6 code kept", 16'(dacCode), 16'h1FFF);
    send(16'hA000);
    chk("R6 serial active in shutdown", 16'(userOut), 16'h1);
    send(16'h6000);
    chk("R4 update wakes", 16'(outEnable), 16'h1);
    send(16'h8000);
  endtask

  task automatic testLock();
    pdLock = 1'b0;
    tick(8);
    send(16'hF000);
    chk("R7 software shutdown refused", 16'(outEnable), 16'h1);
    pdReq = 1'b1;
    tick(8);
    chk("R7 hardware shutdown refused", 16'(outEnable), 16'h1);
    pdReq = 1'b0;
    pdLock = 1'b1;
    tick(8);
    pdReq = 1'b1;
    tick(8);
    chk("R8 pdReq shuts down", 16'(outEnable), 16'h0);
    pdReq = 1'b0;
    tick(8);
    chk("R8 pdReq low keeps shutdown", 16'(outEnable), 16'h0);
    pdLock = 1'b0;
    tick(8);
    chk("R7 lockout fall wakes", 16'(outEnable), 16'h1);
    pdLock = 1'b1;
    tick(8);
  endtask

  task automatic testClear();
    rstVal = 1'b1;
    send(16'hA000);
    send(16'hF000);
    clearPulse();
    chk("R9 clear midscale", 16'(dacCode), 16'h1000);
    chk("R9 clear wakes", 16'(outEnable), 16'h1);
    chk("R9 clear userOut low", 16'(userOut), 16'h0);
    rstVal = 1'b0;
  endtask

  task automatic testDout();
    send(16'hE000);
    send(16'h0A5C);
    shiftWord(16'h0000, 16, 1'b1, 16'h0A5C, 1'b0);
    send(16'hE800);
    send(16'h0A5C);
    shiftWord(16'h0000, 16, 1'b1, 16'h0A5C, 1'b1);
  endtask

  initial begin
    testReset();
    testLoad();
    testShort();
    testUpo();
    testShut();
    testLock();
    testClear();
    testDout();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule